// File: doc/BRIEF.md
# Comparator Trigger Fault Status Bank

This block keeps the comparator-trigger fault status for a set of PWM generators, four by default. Each generator receives eight digital comparator trigger lines and owns one 32-bit status word on a simple register bus. Only the low eight bits of the word carry status.

A per-generator view select decides what a read of that word returns. With the select at 0, a read returns the live trigger levels, and writes do nothing. With the select at 1, a read returns sticky bits. A sticky bit is set by any trigger sampled high and stays set until software writes 1 to it. A per-generator extension enable must also be high for such a clear to be accepted.

The sticky bits capture in the background whatever view is selected. Events that arrive while the live view is shown therefore appear once the sticky view is chosen. Every trigger is captured whether or not the generator uses that source. Reads are registered, and the data comes back with a valid strobe one cycle after the request.

Top module: `fault_status_bank`

## Requirements
- R1: After reset every sticky bit is 0, and bus_rdata_o and bus_rvalid_o are 0.
- R2: Generator g's word sits at byte address 0x808 + 0x80*g (0x808, 0x888, 0x908, 0x988). A read of any other address returns 0, and a write to any other address changes nothing.
- R3: Bits 31:8 of every read response are 0.
- R4: With view select 0, a read returns in bits 7:0 the trigger levels present in the request cycle. Bit b of that field is trigger line b of the generator.
- R5: With view select 1, a read returns the sticky bits. A bit becomes 1 on any clock edge where its trigger is sampled high, and it remains 1 after the trigger falls.
- R6: With view select 1 and extension enable 1, a write clears every sticky bit whose write-data bit (7:0) is 1. Bits written with 0 are unchanged.
- R7: While a generator's extension enable is 0, writes leave its sticky bits unchanged.
- R8: While a generator's view select is 0, writes leave its sticky bits unchanged.
- R9: When a trigger is high in the same cycle as a clear of its bit, the bit ends up 1.
- R10: Triggers sampled while the live view is selected are held in the sticky bits and read back once the sticky view is selected.
- R11: bus_rvalid_o is 1 exactly in the cycle after a cycle with bus_rd_i high.
- R12: A write to one generator's word leaves every other generator's sticky bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 32 | Comparator triggers, generator g in bits [8g+7:8g] |
| view_sel_i | input | 4 | Per-generator view select: 0 live, 1 sticky |
| ext_en_i | input | 4 | Per-generator write acceptance enable |
| bus_addr_i | input | 12 | Byte address of the access |
| bus_wr_i | input | 1 | Write request |
| bus_rd_i | input | 1 | Read request |
| bus_wdata_i | input | 32 | Write data, bits 7:0 select the bits to clear |
| bus_rdata_o | output | 32 | Registered read data |
| bus_rvalid_o | output | 1 | Read response strobe |

## Verification
The assertions assume that the trigger lines, view selects and enables are synchronous to clk and stable around each rising edge. They also assume that at most one address decodes per access and that a read and a write are never requested in the same cycle. The bench changes every input only on the falling clock edge and issues reads and writes in separate cycles. Its addresses are either the four mapped words or addresses well clear of them.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
    localparam int unsigned FSB_GENS     = 4;
    localparam int unsigned FSB_TRIGS    = 8;
    localparam int unsigned FSB_ADDR_W   = 12;
    localparam int unsigned FSB_DATA_W   = 32;
    localparam int unsigned FSB_BASE     = 'h808;
    localparam int unsigned FSB_STRIDE   = 'h80;

    // byte address of one generator's status word
    function automatic int unsigned word_addr(input int unsigned base,
                                              input int unsigned stride,
                                              input int unsigned idx);
        return base + stride * idx;
    endfunction
endpackage

// File: rtl/fsb_addr_decode.sv
module fsb_addr_decode #(
    parameter int unsigned NUM_GEN = fsb_pkg::FSB_GENS,
    parameter int unsigned ADDR_W  = fsb_pkg::FSB_ADDR_W,
    parameter int unsigned BASE    = fsb_pkg::FSB_BASE,
    parameter int unsigned STRIDE  = fsb_pkg::FSB_STRIDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [NUM_GEN-1:0] hit_o
);
    for (genvar g = 0; g < NUM_GEN; g++) begin : g_hit
        localparam logic [ADDR_W-1:0] MY_ADDR =
            ADDR_W'(fsb_pkg::word_addr(BASE, STRIDE, g));
        assign hit_o[g] = (addr_i == MY_ADDR);
    end

    // R2
    one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_o));
endmodule

// File: rtl/fsb_gen_slot.sv
module fsb_gen_slot #(
    parameter int unsigned TRIG_W = fsb_pkg::FSB_TRIGS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TRIG_W-1:0] trig_i,
    input  logic              view_sel_i,
    input  logic              ext_en_i,
    input  logic              hit_i,
    input  logic              wr_i,
    input  logic [TRIG_W-1:0] wmask_i,
    output logic [TRIG_W-1:0] view_o
);
    typedef struct packed {
        logic [TRIG_W-1:0] sticky;
    } slot_t;

    slot_t             st_d, st_q;
    logic              clr_ok;
    logic [TRIG_W-1:0] clr_mask;

    always_comb begin
        st_d     = st_q;
        clr_ok   = wr_i && hit_i && view_sel_i && ext_en_i;
        clr_mask = clr_ok ? wmask_i : '0;
        // a fresh capture outranks a clear in the same cycle
        st_d.sticky = (st_q.sticky & ~clr_mask) | trig_i;
        view_o      = view_sel_i ? st_q.sticky : trig_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5 R9
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.sticky & $past(trig_i)) == $past(trig_i)));

    // R7 R8 R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && hit_i && view_sel_i && ext_en_i)
        |=> ((st_q.sticky & $past(st_q.sticky)) == $past(st_q.sticky)));
endmodule

// File: rtl/fsb_read_port.sv
module fsb_read_port #(
    parameter int unsigned NUM_GEN = fsb_pkg::FSB_GENS,
    parameter int unsigned TRIG_W  = fsb_pkg::FSB_TRIGS,
    parameter int unsigned DATA_W  = fsb_pkg::FSB_DATA_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_i,
    input  logic [NUM_GEN-1:0]        hit_i,
    input  logic [NUM_GEN*TRIG_W-1:0] views_i,
    output logic [DATA_W-1:0]         rdata_o,
    output logic                      rvalid_o
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d        = rsp_q;
        rsp_d.rvalid = rd_i;
        rsp_d.rdata  = '0;
        if (rd_i) begin
            for (int g = 0; g < int'(NUM_GEN); g++) begin
                if (hit_i[g]) rsp_d.rdata[TRIG_W-1:0] = views_i[g*TRIG_W +: TRIG_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rdata_o  = rsp_q.rdata;
    assign rvalid_o = rsp_q.rvalid;

    // R11
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> rvalid_o);
    // R11
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> !rvalid_o);
    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[DATA_W-1:TRIG_W] == '0);
    // R2
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && hit_i == '0) |=> rdata_o == '0);
endmodule

// File: rtl/fault_status_bank.sv
module fault_status_bank #(
    parameter int unsigned NUM_GEN = fsb_pkg::FSB_GENS,
    parameter int unsigned TRIG_W  = fsb_pkg::FSB_TRIGS,
    parameter int unsigned ADDR_W  = fsb_pkg::FSB_ADDR_W,
    parameter int unsigned DATA_W  = fsb_pkg::FSB_DATA_W,
    parameter int unsigned BASE    = fsb_pkg::FSB_BASE,
    parameter int unsigned STRIDE  = fsb_pkg::FSB_STRIDE
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_GEN*TRIG_W-1:0] trig_i,
    input  logic [NUM_GEN-1:0]        view_sel_i,
    input  logic [NUM_GEN-1:0]        ext_en_i,
    input  logic [ADDR_W-1:0]         bus_addr_i,
    input  logic                      bus_wr_i,
    input  logic                      bus_rd_i,
    input  logic [DATA_W-1:0]         bus_wdata_i,
    output logic [DATA_W-1:0]         bus_rdata_o,
    output logic                      bus_rvalid_o
);
    logic [NUM_GEN-1:0]        hit;
    logic [NUM_GEN*TRIG_W-1:0] views;
    logic                      unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata_i[DATA_W-1:TRIG_W];

    fsb_addr_decode #(
        .NUM_GEN(NUM_GEN), .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr_i), .hit_o(hit)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_slot
        fsb_gen_slot #(.TRIG_W(TRIG_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .trig_i    (trig_i[g*TRIG_W +: TRIG_W]),
            .view_sel_i(view_sel_i[g]),
            .ext_en_i  (ext_en_i[g]),
            .hit_i     (hit[g]),
            .wr_i      (bus_wr_i),
            .wmask_i   (bus_wdata_i[TRIG_W-1:0]),
            .view_o    (views[g*TRIG_W +: TRIG_W])
        );
    end

    fsb_read_port #(
        .NUM_GEN(NUM_GEN), .TRIG_W(TRIG_W), .DATA_W(DATA_W)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_i(bus_rd_i), .hit_i(hit),
        .views_i(views), .rdata_o(bus_rdata_o), .rvalid_o(bus_rvalid_o)
    );
endmodule

// File: tb/sim_fault_status_bank.sv
`timescale 1ns/1ps
module sim_fault_status_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] trig = '0;
    logic [3:0]  vsel = '0;
    logic [3:0]  ext = '0;
    logic [11:0] addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fault_status_bank u0 (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .view_sel_i(vsel),
        .ext_en_i(ext), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_rvalid_o(rvalid)
    );

    function automatic logic [11:0] gaddr(input int g);
        return 12'h808 + 12'(g * 'h80);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one write cycle, driven on the falling edge
    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    // read request, response sampled one cycle later
    task automatic do_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
        check("R11 rvalid", {31'd0, rvalid}, 32'd1);
    endtask

    typedef struct packed {
        logic [7:0] trig_a;
        logic       vs;
        logic       en;
        logic       we;
        logic [7:0] wd;
        logic [7:0] trig_b;
        logic [7:0] exp;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'hA5, 8'hA5, 8'd4},  // R4 live
        '{8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h3C, 8'h3C, 8'd4},  // R4 live
        '{8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'hBD, 8'd10}, // R10 background
        '{8'h00, 1'b1, 1'b1, 1'b1, 8'h0F, 8'h00, 8'hB0, 8'd6},  // R6 clear
        '{8'h00, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h00, 8'hB0, 8'd7},  // R7 gated
        '{8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 8'hB0, 8'd6},  // R6 zeros
        '{8'h80, 1'b1, 1'b1, 1'b1, 8'h80, 8'h00, 8'hB0, 8'd9},  // R9 set wins
        '{8'h00, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h11, 8'h11, 8'd8},  // R8 live write
        '{8'h02, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 8'hB3, 8'd5},  // R5 sticky, R8
        '{8'h00, 1'b1, 1'b1, 1'b1, 8'hFF, 8'h00, 8'h00, 8'd6}   // R6 clear all
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rdata", rdata, 32'd0);
        check("R1 rvalid", {31'd0, rvalid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        vsel = 4'b0001;
        do_read(gaddr(0), d);
        check("R1 sticky", d, 32'd0);
        vsel = 4'b0000;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            trig[7:0] = VEC[i].trig_a; vsel[0] = VEC[i].vs; ext[0] = VEC[i].en;
            wr = VEC[i].we; wdata = {24'd0, VEC[i].wd}; addr = gaddr(0);
            @(negedge clk);
            wr = 1'b0; wdata = '0;
            trig[7:0] = VEC[i].trig_b; rd = 1'b1;
            @(negedge clk);
            rd = 1'b0; trig[7:0] = 8'h00;
            tests++;
            if (rdata !== {24'd0, VEC[i].exp}) begin
                fails++;
                $display("FAIL R%0d vector %0d actual=%h expected=%h",
                         VEC[i].req, i, rdata, {24'd0, VEC[i].exp});
            end
            // R3 upper bits
            check("R3 reserved", {8'd0, rdata[31:8]}, 32'd0);
        end

        // R11 no response without request
        @(negedge clk);
        check("R11 idle", {31'd0, rvalid}, 32'd0);

        // R2 unmapped: read returns 0 even with live triggers high
        trig = 32'hFFFF_FFFF; vsel = 4'b0000;
        do_read(12'h80C, d);
        check("R2 unmapped read", d, 32'd0);
        do_read(gaddr(3), d);
        check("R2 gen3 live", d, 32'h0000_00FF);
        @(negedge clk);
        trig = '0;
        // R2 write to unmapped address leaves stickies intact
        vsel = 4'b1111; ext = 4'b1111;
        do_write(12'h800, 32'hFFFF_FFFF);
        do_read(gaddr(2), d);
        check("R2 unmapped write", d, 32'h0000_00FF);

        // R12 independence: clear gen1 only
        do_write(gaddr(1), 32'h0000_00FF);
        do_read(gaddr(1), d);
        check("R12 gen1 cleared", d, 32'd0);
        do_read(gaddr(2), d);
        check("R12 gen2 kept", d, 32'h0000_00FF);
        do_read(gaddr(3), d);
        check("R12 gen3 kept", d, 32'h0000_00FF);

        // R5 capture on gen2 after clearing it, per-line mapping
        do_write(gaddr(2), 32'h0000_00FF);
        @(negedge clk);
        trig[23:16] = 8'h44;
        @(negedge clk);
        trig = '0;
        do_read(gaddr(2), d);
        check("R5 gen2 capture", d, 32'h0000_0044);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule